// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Sender

This block is the sending half of an inter-processor interrupt path. Software programs two 32-bit command words. The high word holds the target identifier. A write to the low word supplies the interrupt vector, the delivery mode, the destination mode, the level and trigger attributes and a destination shorthand, and that same write launches the interrupt at once. The low word also carries a read-only busy flag. The flag is set when the command is launched and cleared when the interconnect confirms delivery.

The shorthand selects the route. An explicit target sends an outbound message to the identifier from the high word. The two broadcast forms send to the all-ones identifier and mark whether the sender is one of the receivers. The self form sends nothing outward: the command loops back for one cycle on a local acceptance output and then counts as delivered. While a command is in flight, further low-word writes are discarded and change nothing. The outbound message uses a valid/ready handshake and stays constant until it is accepted.

Top module: `ipi_cmd_sender`

## Requirements
- R1: After synchronous reset both command words read 0, `msg_valid` is 0 and `loop_valid` is 0.
- R2: A high-word write (`wr_sel`=1) stores bits [31:24] as the destination, and all other bits read 0. It is accepted whether or not a command is busy.
- R3: A low-word write (`wr_sel`=0) while idle stores bits [11:0], [15:14] and [19:18] of the data and sets busy bit [12]. All other bits read 0. The new value is visible after the next clock edge.
- R4: Shorthand [19:18]=00 raises `msg_valid` after the launching edge. The message carries destination = high word [31:24], vector = [7:0], mode = [10:8], destination mode = [11], level = [14], trigger = [15] and `msg_self_incl`=0.
- R5: Shorthand 10 sends the message with destination 0xFF and `msg_self_incl`=1.
- R6: Shorthand 11 sends the message with destination 0xFF and `msg_self_incl`=0.
- R7: Shorthand 01 raises no outbound message. `loop_valid` is high for exactly one cycle after the launching edge, carrying vector, mode, level and trigger. Busy clears on the following edge.
- R8: While `msg_valid` is 1 and `msg_ready` is 0, every message field stays unchanged. `msg_valid` drops on the edge where `msg_ready` is 1.
- R9: A low-word write while busy is discarded: the low word keeps its old value and no new message or loopback appears.
- R10: `resp_valid` clears busy on the next edge and leaves the other low-word bits unchanged.
- R11: When a response and a low-word write fall in the same cycle, the busy flag sampled before that edge decides. If busy, the write is discarded and busy clears. If idle, the write launches and busy stays set.
- R12: A low-word write is also discarded while an earlier outbound message has not yet been accepted, even if busy has already been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the low word, 1 selects the high word |
| wr_data | input | 32 | Write data |
| resp_valid | input | 1 | Delivery confirmation from the interconnect |
| cmd_lo | output | 32 | Low command word readback |
| cmd_hi | output | 32 | High command word readback |
| msg_valid | output | 1 | Outbound message valid |
| msg_ready | input | 1 | Outbound message accepted |
| msg_dest | output | 8 | Message destination identifier |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery mode |
| msg_dest_mode | output | 1 | Message destination mode |
| msg_level | output | 1 | Message level attribute |
| msg_trigger | output | 1 | Message trigger attribute |
| msg_self_incl | output | 1 | Broadcast includes the sender |
| loop_valid | output | 1 | Self-targeted command delivered locally, one-cycle pulse |
| loop_vector | output | 8 | Looped-back vector |
| loop_mode | output | 3 | Looped-back delivery mode |
| loop_level | output | 1 | Looped-back level attribute |
| loop_trigger | output | 1 | Looped-back trigger attribute |

## Verification
A delivery response and a low-word write can reach the block in the same cycle, and the result depends only on the busy flag held before that edge. The bench provokes both orderings. In the first, the write and the response arrive together while a command is in flight; the bench expects the old low word with busy cleared and the original message still held. In the second, the two arrive together while the block is idle; the bench expects the new command to be stored with busy set and a fresh message raised. A related overlap covers a response that clears busy before the outbound message is accepted. A write in that window must still be discarded, and the bench checks this.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    localparam int WORD_W   = 32;
    localparam int VEC_W    = 8;
    localparam int MODE_W   = 3;
    localparam int DEST_W   = 8;
    localparam int BUSY_BIT = 12;
    localparam logic [WORD_W-1:0] LO_WMASK  = 32'h000C_CFFF;
    localparam logic [WORD_W-1:0] BUSY_MASK = 32'h1 << BUSY_BIT;
    localparam logic [WORD_W-1:0] HI_MASK   = 32'hFF00_0000;

    typedef enum logic [1:0] {
        SH_EXPLICIT = 2'd0,
        SH_SELF     = 2'd1,
        SH_ALL_INC  = 2'd2,
        SH_ALL_EXC  = 2'd3
    } shorthand_e;

    typedef struct packed {
        logic [VEC_W-1:0]  vector;
        logic [MODE_W-1:0] mode;
        logic              dest_mode;
        logic              level;
        logic              trigger;
    } ipi_fields_t;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              self_incl;
        ipi_fields_t       f;
    } ipi_msg_t;

    function automatic ipi_fields_t unpack_lo(input logic [WORD_W-1:0] w);
        ipi_fields_t r;
        r.vector    = w[7:0];
        r.mode      = w[10:8];
        r.dest_mode = w[11];
        r.level     = w[14];
        r.trigger   = w[15];
        return r;
    endfunction

    function automatic shorthand_e get_shorthand(input logic [WORD_W-1:0] w);
        return shorthand_e'(w[19:18]);
    endfunction
endpackage

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs
    import ipi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              resp_valid,
    input  logic              loop_done,
    input  logic              out_pending,
    output logic [WORD_W-1:0] lo_q,
    output logic [WORD_W-1:0] hi_q,
    output logic              launch
);
    logic busy;
    assign busy   = lo_q[BUSY_BIT];
    assign launch = wr_en && !wr_sel && !busy && !out_pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (wr_en && wr_sel)
                hi_q <= wr_data & HI_MASK;
            if (launch)
                lo_q <= (wr_data & LO_WMASK) | BUSY_MASK;
            else if (resp_valid || loop_done)
                lo_q[BUSY_BIT] <= 1'b0;
        end
    end

    // R9
    discard_keeps_word_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel && busy) |=> ((lo_q & ~BUSY_MASK) == $past(lo_q & ~BUSY_MASK)));
    // R3
    launch_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
        launch |=> lo_q[BUSY_BIT]);
    // R10
    resp_clears_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && busy) |=> !lo_q[BUSY_BIT]);
    // R2
    hi_low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (hi_q & ~HI_MASK) == '0);
endmodule

// File: rtl/ipi_msg_launch.sv
module ipi_msg_launch
    import ipi_pkg::*;
#(
    parameter logic [DEST_W-1:0] BCAST_DEST = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic [WORD_W-1:0] lo_word,
    input  logic [DEST_W-1:0] hi_dest,
    input  logic              msg_ready,
    output logic              msg_valid,
    output ipi_msg_t          msg_q,
    output logic              loop_valid,
    output ipi_fields_t       loop_q
);
    shorthand_e  sh;
    ipi_fields_t fields;
    ipi_msg_t    msg_d;

    assign sh     = get_shorthand(lo_word);
    assign fields = unpack_lo(lo_word);

    always_comb begin
        msg_d.f = fields;
        unique case (sh)
            SH_EXPLICIT: begin msg_d.dest = hi_dest;    msg_d.self_incl = 1'b0; end
            SH_ALL_INC:  begin msg_d.dest = BCAST_DEST; msg_d.self_incl = 1'b1; end
            SH_ALL_EXC:  begin msg_d.dest = BCAST_DEST; msg_d.self_incl = 1'b0; end
            default:     begin msg_d.dest = '0;         msg_d.self_incl = 1'b0; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid  <= 1'b0;
            msg_q      <= '0;
            loop_valid <= 1'b0;
            loop_q     <= '0;
        end else begin
            loop_valid <= launch && (sh == SH_SELF);
            if (launch && sh == SH_SELF)
                loop_q <= fields;
            if (launch && sh != SH_SELF) begin
                msg_valid <= 1'b1;
                msg_q     <= msg_d;
            end else if (msg_valid && msg_ready) begin
                msg_valid <= 1'b0;
            end
        end
    end

    // R8
    msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_q)));
    // R7
    loop_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        loop_valid |=> !loop_valid);
    // R7
    self_no_msg_chk: assert property (@(posedge clk) disable iff (rst)
        (launch && sh == SH_SELF && !msg_valid) |=> !msg_valid);
endmodule

// File: rtl/ipi_cmd_sender.sv
module ipi_cmd_sender
    import ipi_pkg::*;
#(
    parameter logic [7:0] BCAST_DEST = 8'hFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [31:0] wr_data,
    input  logic        resp_valid,
    output logic [31:0] cmd_lo,
    output logic [31:0] cmd_hi,
    output logic        msg_valid,
    input  logic        msg_ready,
    output logic [7:0]  msg_dest,
    output logic [7:0]  msg_vector,
    output logic [2:0]  msg_mode,
    output logic        msg_dest_mode,
    output logic        msg_level,
    output logic        msg_trigger,
    output logic        msg_self_incl,
    output logic        loop_valid,
    output logic [7:0]  loop_vector,
    output logic [2:0]  loop_mode,
    output logic        loop_level,
    output logic        loop_trigger
);
    logic        launch;
    ipi_msg_t    msg_q;
    ipi_fields_t loop_q;

    ipi_cmd_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .resp_valid  (resp_valid),
        .loop_done   (loop_valid),
        .out_pending (msg_valid),
        .lo_q        (cmd_lo),
        .hi_q        (cmd_hi),
        .launch      (launch)
    );

    ipi_msg_launch #(.BCAST_DEST(BCAST_DEST)) u_launch (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .lo_word    (wr_data),
        .hi_dest    (cmd_hi[31:24]),
        .msg_ready  (msg_ready),
        .msg_valid  (msg_valid),
        .msg_q      (msg_q),
        .loop_valid (loop_valid),
        .loop_q     (loop_q)
    );

    assign msg_dest      = msg_q.dest;
    assign msg_self_incl = msg_q.self_incl;
    assign msg_vector    = msg_q.f.vector;
    assign msg_mode      = msg_q.f.mode;
    assign msg_dest_mode = msg_q.f.dest_mode;
    assign msg_level     = msg_q.f.level;
    assign msg_trigger   = msg_q.f.trigger;
    assign loop_vector   = loop_q.vector;
    assign loop_mode     = loop_q.mode;
    assign loop_level    = loop_q.level;
    assign loop_trigger  = loop_q.trigger;

    // R12
    pending_blocks_launch_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready && wr_en && !wr_sel) |=> $stable(cmd_lo[11:0]));
endmodule

// File: tb/ipi_cmd_sender_test.sv
module ipi_cmd_sender_test;
    logic        clk = 1'b0;
    logic        rst, wr_en, wr_sel, resp_valid, msg_ready;
    logic [31:0] wr_data, cmd_lo, cmd_hi;
    logic        msg_valid, msg_dest_mode, msg_level, msg_trigger, msg_self_incl;
    logic [7:0]  msg_dest, msg_vector, loop_vector;
    logic [2:0]  msg_mode, loop_mode;
    logic        loop_valid, loop_level, loop_trigger;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ipi_cmd_sender uut (.*);

    function automatic logic [31:0] exp_lo(input logic [31:0] d);
        return (d & 32'h000C_CFFF) | 32'h0000_1000;
    endfunction

    function automatic logic [31:0] exp_msg(input logic [31:0] d, input logic [7:0] hd);
        logic [7:0] dst;
        logic       inc;
        dst = (d[19:18] == 2'd0) ? hd : 8'hFF;
        inc = (d[19:18] == 2'd2);
        return {9'd0, dst, inc, d[7:0], d[10:8], d[11], d[14], d[15]};
    endfunction

    function automatic logic [31:0] act_msg();
        return {9'd0, msg_dest, msg_self_incl, msg_vector, msg_mode,
                msg_dest_mode, msg_level, msg_trigger};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d, input logic rsp);
        wr_en = 1'b1; wr_sel = sel; wr_data = d; resp_valid = rsp;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; resp_valid = 1'b0;
    endtask

    task automatic pulse_ready();
        msg_ready = 1'b1; @(posedge clk); @(negedge clk); msg_ready = 1'b0;
    endtask

    task automatic pulse_resp();
        resp_valid = 1'b1; @(posedge clk); @(negedge clk); resp_valid = 1'b0;
    endtask

    // full launch sequence with checks; hd is current high-word destination
    task automatic launch_check(input logic [31:0] d, input logic [7:0] hd);
        logic [31:0] el, em, junk;
        el = exp_lo(d);
        wr(1'b0, d, 1'b0);
        chk("R3 low word after launch", cmd_lo, el);
        if (d[19:18] == 2'd1) begin
            chk("R7 loop_valid", {31'd0, loop_valid}, 32'd1);
            chk("R7 no outbound", {31'd0, msg_valid}, 32'd0);
            chk("R7 loop fields", {19'd0, loop_vector, loop_mode, loop_level, loop_trigger},
                {19'd0, d[7:0], d[10:8], d[14], d[15]});
            @(negedge clk);
            chk("R7 busy cleared", cmd_lo, el & ~32'h1000);
            chk("R7 loop pulse ends", {31'd0, loop_valid}, 32'd0);
        end else begin
            em = exp_msg(d, hd);
            chk("R4 msg_valid", {31'd0, msg_valid}, 32'd1);
            if (d[19:18] == 2'd0)      chk("R4 msg fields", act_msg(), em);
            else if (d[19:18] == 2'd2) chk("R5 msg fields", act_msg(), em);
            else                       chk("R6 msg fields", act_msg(), em);
            repeat ($urandom_range(2)) begin
                @(negedge clk);
                chk("R8 held", act_msg(), em);
            end
            junk = $urandom;
            wr(1'b0, junk, 1'b0);
            chk("R9 word kept", cmd_lo, el);
            chk("R9 msg kept", act_msg(), em);
            chk("R8 still valid", {31'd0, msg_valid}, 32'd1);
            pulse_ready();
            chk("R8 valid drops", {31'd0, msg_valid}, 32'd0);
            pulse_resp();
            chk("R10 busy cleared", cmd_lo, el & ~32'h1000);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d1, d2, h;
        void'($urandom(32'd2024));
        rst = 1'b1; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
        resp_valid = 1'b0; msg_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        chk("R1 lo", cmd_lo, 32'd0);
        chk("R1 hi", cmd_hi, 32'd0);
        chk("R1 valids", {30'd0, msg_valid, loop_valid}, 32'd0);

        wr(1'b1, 32'hA5FF_FFFF, 1'b0);
        chk("R2 hi mask", cmd_hi, 32'hA500_0000);

        launch_check(32'h0000_C321, 8'hA5);   // explicit
        launch_check(32'h0008_4140, 8'hA5);   // all incl
        launch_check(32'h000C_8A07, 8'hA5);   // all excl
        launch_check(32'hFFF7_EFFF, 8'hA5);   // self, upper junk

        // R2 high write while busy, R11 response with discarded write
        d1 = 32'h0000_0455;
        wr(1'b0, d1, 1'b0);
        wr(1'b1, 32'h3C00_0000, 1'b0);
        chk("R2 hi while busy", cmd_hi, 32'h3C00_0000);
        chk("R2 msg dest captured", act_msg(), exp_msg(d1, 8'hA5));
        wr(1'b0, 32'h0000_0099, 1'b1);
        chk("R11 busy write+resp", cmd_lo, exp_lo(d1) & ~32'h1000);
        chk("R11 msg kept", act_msg(), exp_msg(d1, 8'hA5));
        // R12 write discarded while message unaccepted
        wr(1'b0, 32'h0000_0077, 1'b0);
        chk("R12 word kept", cmd_lo, exp_lo(d1) & ~32'h1000);
        chk("R12 msg kept", act_msg(), exp_msg(d1, 8'hA5));
        pulse_ready();
        chk("R8 accepted", {31'd0, msg_valid}, 32'd0);
        // R11 idle write+resp: launch wins
        d2 = 32'h0000_8E10;
        wr(1'b0, d2, 1'b1);
        chk("R11 idle write+resp", cmd_lo, exp_lo(d2));
        chk("R11 msg raised", {31'd0, msg_valid}, 32'd1);
        chk("R11 msg fields", act_msg(), exp_msg(d2, 8'h3C));
        pulse_ready();
        pulse_resp();
        chk("R10 idle", cmd_lo, exp_lo(d2) & ~32'h1000);

        for (int i = 0; i < 150; i++) begin
            h = $urandom;
            wr(1'b1, h, 1'b0);
            chk("R2 hi random", cmd_hi, h & 32'hFF00_0000);
            launch_check($urandom, h[31:24]);
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule